// File: doc/BRIEF.md
# Synchronized Leading/Trailing Edge Modulator

This block turns two digitized duty commands into two gate-drive pulse trains that share one timebase. A free-running counter serves as the ramp. Each switching cycle is a ramp interval of `2**CMD_W` clocks followed by a dead-time interval of `DEAD_LEN` clocks. A strobe marks the first clock of every cycle.

The boost drive uses leading-edge modulation. It starts each cycle low and switches on once the ramp passes its command, so a larger command gives a shorter on time. The converter drive uses trailing-edge modulation. It starts each cycle high and switches off once the ramp reaches its command minus a fixed offset. Its on time is capped below half the period.

Each output has its own cycle-by-cycle current-limit latch and its own enable. Commands are captured only at cycle start.

Top module: `edge_mod_pair`

## Requirements
- R1: `cyc_start` is high for exactly one clock per cycle and the period is 272 clocks (256 ramp plus 16 dead). The first cycle begins on the first rising edge after `rst` is released, and the slot that follows that edge is slot 0.
- R2: In slot k of the ramp, `boost_drv` is high only when k > max(latched boost command, 4). With a command of 255 the output never goes high.
- R3: `boost_drv` is low in all 16 dead-time slots (slots 256 to 271).
- R4: With a boost command of 4 or less, `boost_drv` is high for exactly 251 slots per cycle (slots 5 to 255), which is about 92% of the period.
- R5: `conv_drv` is high from slot 0 for (latched converter command − 64) slots, then low for the rest of the cycle.
- R6: `conv_drv` is never high for more than 125 slots in one cycle, which is below half the period. Any command of 189 or more gives exactly 125 slots.
- R7: A converter command of 64 or less gives 0% duty: `conv_drv` stays low for the whole cycle.
- R8: If `boost_ilim` is high at a rising edge other than the one that ends slot 271, `boost_drv` is low from the next slot until the end of that cycle. A flag at the edge that ends slot 271 is ignored.
- R9: The rule of R8 applies in the same way to `conv_ilim` and `conv_drv`.
- R10: Commands are captured only at the edge that starts a cycle. A command change during a cycle has no effect on either output in that cycle.
- R11: While `boost_en` or `conv_en` is low, the matching output is low, and the other output is unaffected.
- R12: While `rst` is high, both drives and `cyc_start` are low. Releasing `rst` starts a fresh cycle with the commands present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one clock is one ramp step |
| rst | input | 1 | Synchronous reset, active high |
| boost_en | input | 1 | Enable for the leading-edge output |
| conv_en | input | 1 | Enable for the trailing-edge output |
| boost_cmd | input | CMD_W | Boost command, unsigned; higher means less duty |
| conv_cmd | input | CMD_W | Converter command, unsigned; higher means more duty |
| boost_ilim | input | 1 | Boost current-limit flag |
| conv_ilim | input | 1 | Converter current-limit flag |
| boost_drv | output | 1 | Leading-edge gate drive |
| conv_drv | output | 1 | Trailing-edge gate drive |
| cyc_start | output | 1 | High during the first slot of each cycle |

## Verification
The bench aims at the edges of each threshold:
- **Boost command at or below the minimum off time.** A design with the wrong clamp would switch on in slot 0 or slot 1 and lose the guaranteed off interval.
- **Converter command at 63, 64, 65, 189 and 190.** An off-by-one around the offset would emit a one-slot sliver at the zero-duty command. A missing ceiling would let the on time run past half the period.

Current-limit flags are fired at random slots, including the final dead slot. A latch that clears too early would let the output switch back on within the same cycle, and one that clears too late would suppress the following cycle.

Commands are scrambled during a cycle, and enables are dropped during a cycle. Together these catch designs that compare against the live inputs instead of the copy captured at cycle start.

// File: rtl/edge_mod_pair.sv
module edge_mod_pair #(
  parameter int CMD_W     = 8,
  parameter int DEAD_LEN  = 16,
  parameter int OFFSET    = 64,
  parameter int C_MAX_ON  = 125,
  parameter int B_MIN_OFF = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boost_en,
  input  logic             conv_en,
  input  logic [CMD_W-1:0] boost_cmd,
  input  logic [CMD_W-1:0] conv_cmd,
  input  logic             boost_ilim,
  input  logic             conv_ilim,
  output logic             boost_drv,
  output logic             conv_drv,
  output logic             cyc_start
);
  localparam int RAMP_LEN = 1 << CMD_W;
  localparam int PERIOD   = RAMP_LEN + DEAD_LEN;
  localparam int CNT_W    = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] RAMP_END = CNT_W'(RAMP_LEN);
  localparam logic [CMD_W-1:0] OFS      = CMD_W'(OFFSET);
  localparam logic [CMD_W-1:0] CMAX     = CMD_W'(C_MAX_ON);
  localparam logic [CMD_W-1:0] BMIN     = CMD_W'(B_MIN_OFF);

  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] b_cmd_q, c_cmd_q;
  logic             b_lim, c_lim;
  logic [CMD_W-1:0] b_thr, c_on, c_diff;
  logic             wrap, in_ramp;

  assign wrap    = (cnt == LAST);
  assign in_ramp = (cnt < RAMP_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= LAST;
      b_cmd_q <= '0;
      c_cmd_q <= '0;
      b_lim   <= 1'b0;
      c_lim   <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      b_cmd_q <= boost_cmd;
      c_cmd_q <= conv_cmd;
      b_lim   <= 1'b0;
      c_lim   <= 1'b0;
    end else begin
      cnt   <= cnt + CNT_W'(1);
      b_lim <= b_lim | boost_ilim;
      c_lim <= c_lim | conv_ilim;
    end
  end

  assign b_thr  = (b_cmd_q > BMIN) ? b_cmd_q : BMIN;
  assign c_diff = c_cmd_q - OFS;

  always_comb begin
    if (c_cmd_q <= OFS)     c_on = '0;
    else if (c_diff > CMAX) c_on = CMAX;
    else                    c_on = c_diff;
  end

  assign boost_drv = ~rst & boost_en & ~b_lim & in_ramp &
                     (cnt > {{(CNT_W-CMD_W){1'b0}}, b_thr});
  assign conv_drv  = ~rst & conv_en & ~c_lim &
                     (cnt < {{(CNT_W-CMD_W){1'b0}}, c_on});
  assign cyc_start = ~rst & (cnt == '0);

  logic [CNT_W-1:0] c_run;
  always_ff @(posedge clk) begin
    if (rst || !conv_drv) c_run <= '0;
    else                  c_run <= c_run + CNT_W'(1);
  end

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start);

  // R2
  boost_off_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> !boost_drv);

  // R3
  boost_dead_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ramp |-> !boost_drv);

  // R6
  conv_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    c_run <= CNT_W'(C_MAX_ON));

  // R7
  conv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && c_cmd_q <= OFS) |-> !conv_drv);

  // R8
  boost_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (boost_ilim && !wrap) |=> !boost_drv);

  // R9
  conv_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_ilim && !wrap) |=> !conv_drv);

  // R10
  conv_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(conv_drv) && $past(conv_en)) |-> cyc_start);
endmodule

// File: tb/edge_mod_pair_test.sv
module edge_mod_pair_test;
  localparam int RAMP = 256;
  localparam int PER  = 272;
  localparam int OFS  = 64;
  localparam int CMAX = 125;
  localparam int BMIN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boost_en = 1'b1, conv_en = 1'b1;
  logic [7:0] boost_cmd = '0, conv_cmd = '0;
  logic boost_ilim = 1'b0, conv_ilim = 1'b0;
  logic boost_drv, conv_drv, cyc_start;

  int checks = 0, failures = 0;
  int cur_b = 0, cur_c = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edge_mod_pair uut (
    .clk(clk), .rst(rst), .boost_en(boost_en), .conv_en(conv_en),
    .boost_cmd(boost_cmd), .conv_cmd(conv_cmd),
    .boost_ilim(boost_ilim), .conv_ilim(conv_ilim),
    .boost_drv(boost_drv), .conv_drv(conv_drv), .cyc_start(cyc_start)
  );

  function automatic bit exp_boost(int k, int cmd, bit lim, bit en);
    int thr = (cmd > BMIN) ? cmd : BMIN;
    return en && !lim && k < RAMP && k > thr;
  endfunction

  function automatic bit exp_conv(int k, int cmd, bit lim, bit en);
    int on = (cmd <= OFS) ? 0 : cmd - OFS;
    if (on > CMAX) on = CMAX;
    return en && !lim && k < on;
  endfunction

  task automatic chk(string tag, logic got, logic exp, int k);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s slot %0d got %0b exp %0b", tag, k, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one full cycle; nb/nc are loaded at its closing edge
  task automatic run_cycle(string tb, string tc, int nb, int nc,
                           int pb, int pc, bit noise, int en_off, int en_on,
                           int stop_at);
    bit lb = 0, lc = 0;
    int on_b = 0, on_c = 0;
    for (int k = 0; k < PER; k++) begin
      @(negedge clk);
      if (k == stop_at) return;
      chk("R1", cyc_start, k == 0, k);
      chk(k >= RAMP ? "R3" : lb ? "R8" : !boost_en ? "R11" : tb,
          boost_drv, exp_boost(k, cur_b, lb, boost_en), k);
      chk(lc ? "R9" : !conv_en ? "R11" : tc,
          conv_drv, exp_conv(k, cur_c, lc, conv_en), k);
      on_b += boost_drv;
      on_c += conv_drv;
      if (k < PER - 1) begin
        boost_ilim = ($urandom % 1000) < pb;
        conv_ilim  = ($urandom % 1000) < pc;
        lb = lb | boost_ilim;
        lc = lc | conv_ilim;
        if (noise) begin
          boost_cmd = 8'($urandom);
          conv_cmd  = 8'($urandom);
        end
        if (k == en_off) begin boost_en = 0; conv_en = 0; end
        if (k == en_on)  begin boost_en = 1; conv_en = 1; end
      end else begin
        boost_ilim = ($urandom % 2) == 1;   // ignored at the closing edge (R8)
        conv_ilim  = ($urandom % 2) == 1;
        boost_cmd = 8'(nb);
        conv_cmd  = 8'(nc);
      end
    end
    if (pb == 0 && en_off < 0 && tb == "R4")
      chk("R4", on_b == 251, 1'b1, PER);
    if (pc == 0 && en_off < 0 && tc == "R6")
      chk("R6", on_c == CMAX, 1'b1, PER);
    cur_b = nb;
    cur_c = nc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2718));
    boost_cmd = 8'd100; conv_cmd = 8'd150;
    repeat (4) begin
      @(negedge clk);
      chk("R12", boost_drv, 1'b0, -1);
      chk("R12", conv_drv, 1'b0, -1);
      chk("R12", cyc_start, 1'b0, -1);
    end
    cur_b = 100; cur_c = 150;
    rst = 0;
    run_cycle("R2", "R5", 0, 255, 0, 0, 0, -1, -1, -1);
    run_cycle("R4", "R6", 255, 64, 0, 0, 0, -1, -1, -1);
    run_cycle("R2", "R7", 3, 63, 0, 0, 0, -1, -1, -1);
    run_cycle("R4", "R7", 5, 65, 0, 0, 0, -1, -1, -1);
    run_cycle("R2", "R5", 4, 189, 0, 0, 0, -1, -1, -1);
    run_cycle("R4", "R6", 200, 190, 0, 0, 0, -1, -1, -1);
    run_cycle("R2", "R6", 30, 120, 0, 0, 1, -1, -1, -1);
    run_cycle("R10", "R10", 0, 255, 0, 0, 1, -1, -1, -1);
    run_cycle("R4", "R6", 10, 200, 0, 0, 1, -1, -1, -1);
    run_cycle("R2", "R5", 40, 160, 10, 10, 0, -1, -1, -1);
    run_cycle("R8", "R9", 0, 255, 10, 10, 0, -1, -1, -1);
    run_cycle("R8", "R9", 60, 110, 0, 0, 0, 30, 150, -1);
    run_cycle("R11", "R11", 20, 140, 0, 0, 0, 0, 200, -1);
    for (int i = 0; i < 18; i++)
      run_cycle("R2", "R5", int'($urandom % 256), int'($urandom % 256),
                (i % 3 == 0) ? 6 : 0, (i % 3 == 1) ? 6 : 0,
                i % 2 == 1, -1, -1, -1);
    // reset in the middle of a cycle
    run_cycle("R2", "R5", 0, 0, 0, 0, 0, -1, -1, 90);
    rst = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R12", boost_drv, 1'b0, -1);
      chk("R12", conv_drv, 1'b0, -1);
      chk("R12", cyc_start, 1'b0, -1);
    end
    boost_cmd = 8'd50; conv_cmd = 8'd100;
    cur_b = 50; cur_c = 100;
    rst = 0;
    run_cycle("R12", "R12", 0, 255, 0, 0, 0, -1, -1, -1);
    run_cycle("R4", "R6", 0, 0, 0, 0, 0, -1, -1, -1);
    summary();
  end
endmodule